// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Port

This block collects up to 32 interrupt request lines, records them in a status register and masks them with an enable register. It reports the lowest-numbered active pending source as a vector and drives one combined interrupt line to a processor. Software reaches it through a small synchronous word-register port. The port decodes eight word registers from a byte address.

An elaboration parameter marks each source as level-type or edge-type. Level-type sources set their status bit in every clock where they are high. Edge-type sources set it only on a low-to-high change. Both kinds are captured only while the capture control bit is set. While capture is off, software may write the status register directly to raise interrupts. Dedicated write-one-to-set and write-one-to-clear words change the enable register, and an acknowledge word clears status bits. A two-bit master register gates hardware capture and the output line.

Top module: `irq_vec_ctrl`

## Requirements
- R1: The word index is the byte address shifted right by two. Words 0..7 are: status, pending, enable, acknowledge, set-enable, clear-enable, vector and master. The low two address bits are ignored. Read data appears on `rdata` one clock after the address is presented. The acknowledge, set-enable and clear-enable words read as zero, and writes to pending or vector have no effect.
- R2: Pending (word 1) equals status AND enable at all times.
- R3: Vector (word 6) holds the index of the lowest set pending bit. It reads all ones when no bit is pending.
- R4: `irq_out` is high exactly when master bit 0 is 1 and at least one pending bit is set.
- R5: A write to master (word 7) keeps only data bits 1:0. Bit 0 enables the output and bit 1 enables hardware capture.
- R6: While master bit 1 is set, a level-type source that is high sets its status bit on every clock, including right after an acknowledge. While master bit 1 is clear, no source sets a status bit.
- R7: A source whose bit in `EDGE_MASK` is 1 sets its status bit only on a clock where it is 1 and was 0 on the previous clock, and only while master bit 1 is set. A source held high does not set the bit again.
- R8: Writing acknowledge (word 3) clears each status bit whose data bit is 1, unless hardware capture sets it again in the same clock.
- R9: Writing set-enable (word 4) ORs the data into enable. Writing clear-enable (word 5) clears each enable bit whose data bit is 1.
- R10: A write to status (word 0) replaces status while master bit 1 is clear. The write is ignored while master bit 1 is set.
- R11: After reset, status, enable and master are zero, vector reads all ones and `irq_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| addr | input | ADDR_W | Byte address of the register access |
| wdata | input | DATA_W | Write data |
| we | input | 1 | Write strobe for the current cycle |
| rdata | output | DATA_W | Registered read data for the previous cycle's address |
| irq_in | input | NUM_SRC | Interrupt request lines |
| irq_out | output | 1 | Combined interrupt request to the processor |

## Verification
The priority encoder is driven by a sweep of status patterns whose lowest set bit walks from 0 to 31, and then by a sweep that clears enables one at a time. The first sweep shows that the lowest index wins rather than any higher one. The second shows that masking feeds the encoder and that it falls back to all ones when nothing is pending. Acknowledge patterns strip the low bits in groups. Level and edge sources are driven with capture off, held high across an acknowledge, and toggled. These patterns separate re-assertion by level from one-shot setting by edge, and show that the status write is gated by the capture bit.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int WORD_SHIFT = 2;
  localparam int SEL_W      = 3;

  typedef enum logic [SEL_W-1:0] {
    REG_STAT   = 3'd0,
    REG_PEND   = 3'd1,
    REG_ENAB   = 3'd2,
    REG_ACK    = 3'd3,
    REG_SETEN  = 3'd4,
    REG_CLREN  = 3'd5,
    REG_VEC    = 3'd6,
    REG_MASTER = 3'd7
  } reg_sel_e;

  localparam int MST_OUT_BIT = 0;
  localparam int MST_CAP_BIT = 1;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int                 NUM_SRC   = 32,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_en,
  input  logic [NUM_SRC-1:0] irq_in,
  output logic [NUM_SRC-1:0] hw_set
);
  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] prev_n;
  logic [NUM_SRC-1:0] raw_set;

  always_comb begin
    prev_n  = irq_in;
    // level sources pass straight through, edge sources need a low previous sample
    raw_set = irq_in & ~(prev_q & EDGE_MASK);
    hw_set  = cap_en ? raw_set : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_n;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic [NUM_SRC-1:0] pend,
  output logic [DATA_W-1:0]  vec,
  output logic               any
);
  always_comb begin
    vec = '1;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) vec = DATA_W'(i);
    end
    any = |pend;
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_vec_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   word_sel,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               we,
  input  logic [NUM_SRC-1:0] hw_set,
  input  logic [DATA_W-1:0]  vec,
  output logic [NUM_SRC-1:0] status,
  output logic [NUM_SRC-1:0] enable,
  output logic [1:0]         master,
  output logic [NUM_SRC-1:0] pend,
  output logic [DATA_W-1:0]  rdata
);
  reg_sel_e           sel;
  logic [NUM_SRC-1:0] wbits;
  logic [NUM_SRC-1:0] status_n;
  logic [NUM_SRC-1:0] enable_n;
  logic [1:0]         master_n;
  logic [DATA_W-1:0]  rdata_n;
  logic               status_en;
  logic               enable_en;
  logic               master_en;
  logic               wr_stat;
  logic               wr_ack;

  assign sel   = reg_sel_e'(word_sel);
  assign wbits = wbits_of(wdata);
  assign pend  = status & enable;

  function automatic logic [NUM_SRC-1:0] wbits_of(input logic [DATA_W-1:0] d);
    return d[NUM_SRC-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] widen(input logic [NUM_SRC-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[NUM_SRC-1:0] = v;
    return r;
  endfunction

  // status: software write while capture is off, acknowledge clears, capture sets last
  always_comb begin
    wr_stat  = we && (sel == REG_STAT) && !master[MST_CAP_BIT];
    wr_ack   = we && (sel == REG_ACK);
    status_n = status;
    if (wr_stat) status_n = wbits;
    if (wr_ack)  status_n = status_n & ~wbits;
    status_n  = status_n | hw_set;
    status_en = wr_stat || wr_ack || (|hw_set);
  end

  always_comb begin
    enable_n  = enable;
    enable_en = 1'b0;
    if (we && sel == REG_SETEN) begin
      enable_n  = enable | wbits;
      enable_en = 1'b1;
    end else if (we && sel == REG_CLREN) begin
      enable_n  = enable & ~wbits;
      enable_en = 1'b1;
    end
  end

  always_comb begin
    master_en = we && (sel == REG_MASTER);
    master_n  = wdata[1:0];
  end

  always_comb begin
    unique case (sel)
      REG_STAT:   rdata_n = widen(status);
      REG_PEND:   rdata_n = widen(pend);
      REG_ENAB:   rdata_n = widen(enable);
      REG_VEC:    rdata_n = vec;
      REG_MASTER: rdata_n = DATA_W'(master);
      default:    rdata_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status <= '0;
    else if (status_en) status <= status_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         enable <= '0;
    else if (enable_en) enable <= enable_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         master <= 2'b00;
    else if (master_en) master <= master_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_n;
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int                 NUM_SRC   = 32,
  parameter int                 DATA_W    = 32,
  parameter int                 ADDR_W    = 5,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               we,
  output logic [DATA_W-1:0]  rdata,
  input  logic [NUM_SRC-1:0] irq_in,
  output logic               irq_out
);
  logic               srst_n;
  logic [SEL_W-1:0]   word_sel;
  logic [NUM_SRC-1:0] hw_set;
  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] enable;
  logic [NUM_SRC-1:0] pend;
  logic [1:0]         master;
  logic [DATA_W-1:0]  vec;
  logic               any_pend;

  assign word_sel = SEL_W'(addr >> WORD_SHIFT);

  irq_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  irq_capture #(
    .NUM_SRC   (NUM_SRC),
    .EDGE_MASK (EDGE_MASK)
  ) u_cap (
    .clk    (clk),
    .rst_n  (srst_n),
    .cap_en (master[MST_CAP_BIT]),
    .irq_in (irq_in),
    .hw_set (hw_set)
  );

  irq_regs #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (srst_n),
    .word_sel (word_sel),
    .wdata    (wdata),
    .we       (we),
    .hw_set   (hw_set),
    .vec      (vec),
    .status   (status),
    .enable   (enable),
    .master   (master),
    .pend     (pend),
    .rdata    (rdata)
  );

  irq_prio_enc #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W)
  ) u_enc (
    .pend (pend),
    .vec  (vec),
    .any  (any_pend)
  );

  assign irq_out = master[MST_OUT_BIT] & any_pend;
endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk #(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               srst_n,
  input logic               we,
  input logic [2:0]         word_sel,
  input logic [DATA_W-1:0]  wdata,
  input logic [NUM_SRC-1:0] status,
  input logic [NUM_SRC-1:0] enable,
  input logic [1:0]         master
);
  logic [NUM_SRC-1:0] wb;
  assign wb = wdata[NUM_SRC-1:0];

  AST_MASTER_TWO_BITS: assert property (@(posedge clk) disable iff (!srst_n)
    (we && word_sel == 3'd7) |=> (master == $past(wdata[1:0]))); // R5

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!srst_n)
    (we && word_sel == 3'd3 && !master[1]) |=> ((status & $past(wb)) == '0)); // R8

  AST_SETEN_ORS: assert property (@(posedge clk) disable iff (!srst_n)
    (we && word_sel == 3'd4) |=> ((enable & $past(wb)) == $past(wb) && (enable & $past(enable)) == $past(enable))); // R9

  AST_CLREN_CLEARS: assert property (@(posedge clk) disable iff (!srst_n)
    (we && word_sel == 3'd5) |=> ((enable & $past(wb)) == '0)); // R9

  AST_SW_STATUS_WRITE: assert property (@(posedge clk) disable iff (!srst_n)
    (we && word_sel == 3'd0 && !master[1]) |=> (status == $past(wb))); // R10

  AST_NO_CAPTURE_WHEN_OFF: assert property (@(posedge clk) disable iff (!srst_n)
    (!master[1] && !(we && word_sel == 3'd0)) |=> ((status & ~$past(status)) == '0)); // R6
endmodule

bind irq_vec_ctrl irq_vec_chk #(
  .NUM_SRC (NUM_SRC),
  .DATA_W  (DATA_W)
) u_chk (
  .clk      (clk),
  .srst_n   (srst_n),
  .we       (we),
  .word_sel (word_sel),
  .wdata    (wdata),
  .status   (status),
  .enable   (enable),
  .master   (master)
);

// File: tb/irq_vec_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb;
  localparam logic [31:0] EDGES = 32'hFFFF_0000;

  logic        clk;
  logic        rst_n;
  logic [4:0]  addr;
  logic [31:0] wdata;
  logic        we;
  logic [31:0] rdata;
  logic [31:0] irq_in;
  logic        irq_out;

  int total;
  int bad;
  bit done;

  irq_vec_ctrl #(
    .NUM_SRC   (32),
    .DATA_W    (32),
    .ADDR_W    (5),
    .EDGE_MASK (EDGES)
  ) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wdata   (wdata),
    .we      (we),
    .rdata   (rdata),
    .irq_in  (irq_in),
    .irq_out (irq_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] w, input logic [31:0] d);
    @(negedge clk);
    addr  = {w, 2'b00};
    wdata = d;
    we    = 1'b1;
    @(negedge clk);
    we    = 1'b0;
  endtask

  task automatic rdb(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    we   = 1'b0;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic rd(input logic [2:0] w, output logic [31:0] d);
    rdb({w, 2'b00}, d);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic logic [31:0] low_idx(input logic [31:0] p);
    logic [31:0] r;
    r = 32'hFFFF_FFFF;
    for (int i = 31; i >= 0; i--) if (p[i]) r = i;
    return r;
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] exp_st;
    logic [31:0] exp_en;
    total = 0; bad = 0; done = 0;
    rst_n = 1'b0; addr = '0; wdata = '0; we = 1'b0; irq_in = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R11 / R1: reset values
    rd(3'd0, d); chk("R11 status", d, 32'h0);
    rd(3'd1, d); chk("R11 pending", d, 32'h0);
    rd(3'd2, d); chk("R11 enable", d, 32'h0);
    rd(3'd7, d); chk("R11 master", d, 32'h0);
    rd(3'd6, d); chk("R11 vector", d, 32'hFFFF_FFFF);
    chk("R11 irq_out", {31'b0, irq_out}, 32'h0);

    // R5: only two master bits kept
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd7, d); chk("R5 master mask", d, 32'h3);
    wr(3'd7, 32'h1);
    rd(3'd7, d); chk("R5 master write", d, 32'h1);

    // R9 set-enable
    wr(3'd4, 32'h0000_FFFF);
    wr(3'd4, 32'hFFFF_0000);
    rd(3'd2, d); chk("R9 set-enable or", d, 32'hFFFF_FFFF);
    exp_en = 32'hFFFF_FFFF;

    // R3 / R2 / R4 / R10: lowest set bit walks upward
    for (int i = 0; i < 32; i++) begin
      exp_st = 32'hFFFF_FFFF << i;
      wr(3'd0, exp_st);
      rd(3'd0, d); chk("R10 status write", d, exp_st);
      rd(3'd6, d); chk("R3 vector sweep", d, low_idx(exp_st & exp_en));
      rd(3'd1, d); chk("R2 pending sweep", d, exp_st & exp_en);
      chk("R4 irq_out sweep", {31'b0, irq_out}, 32'h1);
    end

    // R9 clear-enable sweep, R3 fall back to all ones
    exp_st = 32'hFFFF_FFFF;
    wr(3'd0, exp_st);
    for (int i = 0; i < 32; i++) begin
      wr(3'd5, 32'h1 << i);
      exp_en = exp_en & ~(32'h1 << i);
      rd(3'd2, d); chk("R9 clear-enable", d, exp_en);
      rd(3'd6, d); chk("R3 vector masked", d, low_idx(exp_st & exp_en));
      chk("R4 irq_out masked", {31'b0, irq_out}, {31'b0, (exp_en != 0)});
    end

    // R8 acknowledge patterns
    wr(3'd4, 32'hFFFF_FFFF);
    exp_en = 32'hFFFF_FFFF;
    wr(3'd3, 32'h0000_00F0); exp_st = exp_st & ~32'h0000_00F0;
    rd(3'd0, d); chk("R8 ack group", d, exp_st);
    rd(3'd6, d); chk("R8 vector after ack", d, 32'h0);
    wr(3'd3, 32'h0000_000F); exp_st = exp_st & ~32'h0000_000F;
    rd(3'd0, d); chk("R8 ack low", d, exp_st);
    rd(3'd6, d); chk("R8 vector moves", d, 32'd8);

    // R4: master bit 0 gates the output
    wr(3'd7, 32'h0);
    chk("R4 output gated", {31'b0, irq_out}, 32'h0);
    rd(3'd1, d); chk("R2 pending with output off", d, exp_st);

    // R1: alias words read zero, low address bits ignored, vector not writable
    rd(3'd3, d); chk("R1 ack reads zero", d, 32'h0);
    rd(3'd4, d); chk("R1 set-enable reads zero", d, 32'h0);
    rd(3'd5, d); chk("R1 clear-enable reads zero", d, 32'h0);
    rdb(5'b010_11, d); chk("R1 low address bits", d, 32'hFFFF_FFFF);
    wr(3'd6, 32'h0000_0005);
    rd(3'd6, d); chk("R1 vector read-only", d, 32'd8);
    wr(3'd1, 32'h0);
    rd(3'd1, d); chk("R1 pending read-only", d, exp_st);

    // R6 / R7: nothing captured while capture is off
    wr(3'd0, 32'h0);
    irq_in[3]  = 1'b1;
    irq_in[20] = 1'b1;
    idle(3);
    rd(3'd0, d); chk("R6 R7 no capture when off", d, 32'h0);

    // R6: level source captured, R7: edge already high is not
    wr(3'd7, 32'h2);
    idle(2);
    rd(3'd0, d); chk("R6 level captured", d, 32'h0000_0008);
    chk("R4 output off with capture", {31'b0, irq_out}, 32'h0);
    wr(3'd3, 32'h0000_0008);
    rd(3'd0, d); chk("R6 level re-sets after ack", d, 32'h0000_0008);
    irq_in[3] = 1'b0;
    wr(3'd3, 32'h0000_0008);
    rd(3'd0, d); chk("R6 level cleared once low", d, 32'h0);

    // R7: edge source toggled
    @(negedge clk); irq_in[20] = 1'b0;
    idle(2);
    rd(3'd0, d); chk("R7 falling edge ignored", d, 32'h0);
    @(negedge clk); irq_in[20] = 1'b1;
    idle(2);
    rd(3'd0, d); chk("R7 rising edge sets", d, 32'h0010_0000);
    wr(3'd3, 32'h0010_0000);
    idle(3);
    rd(3'd0, d); chk("R7 held high no re-set", d, 32'h0);

    // R10: status write ignored while capture is on
    wr(3'd0, 32'h0000_0005);
    rd(3'd0, d); chk("R10 write ignored", d, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule